// File: doc/BRIEF.md
# CPU Memory Bank Address Mapper

This block sits between an 8-bit processor with a 64 KB address space and the physical memories behind it: a three-page internal ROM, a plug-in ROM cartridge, a main RAM that may carry an expansion area above 64 KB, and an 8 KB video RAM. The processor loads one 8-bit bank control register through an I/O write strobe. From that register and the current address, the mapper produces a chip select, a translated physical address and a write enable for every bus cycle. It also returns the read data from the device that was hit.

The address space is divided into four windows of unequal size. The low 32 KB can show a ROM page, the cartridge, or either half of main RAM. The next 16 KB shows one of three RAM pages, or the expansion RAM when that is fitted. The following 10 KB is either plain RAM or video RAM followed by a hole. The top 6 KB is always plain RAM. A read that reaches no device returns all ones. A register value that asks for a meaningless setting raises a sticky error flag, which software reads as an output and clears through a strobe.

Top module: `bank_mapper`

## Requirements
- R1: After reset the bank register reads 00h and the error flag is low. A read in 0000h-7FFFh then selects the internal ROM with physical address equal to the CPU address.
- R2: With bank bits 3:2 = 0 and bits 1:0 = p, where p is 0, 1 or 2, a read in 0000h-7FFFh asserts the ROM select with physical address p*8000h + (address & 7FFFh).
- R3: With bank bits 3:2 = 0 and bits 1:0 = 3, a read in 0000h-7FFFh asserts the cartridge select with physical address equal to the CPU address, but only while cartPresent is high. While cartPresent is low the window is unmapped and the cartridge select never asserts.
- R4: While 0000h-7FFFh shows ROM or cartridge (bits 3:2 = 0), a write there asserts no chip select and leaves memWe low.
- R5: With bits 3:2 = 1, 0000h-7FFFh maps read/write onto RAM at the same address. With bits 3:2 = 2, it maps onto RAM at address + 8000h.
- R6: With bits 3:2 = 3, 0000h-7FFFh is unmapped for reads and writes.
- R7: With bank bits 5:4 = q, where q is 0, 1 or 2, 8000h-BFFFh maps read/write onto RAM at q*4000h + (address - 8000h).
- R8: With bits 5:4 = 3, 8000h-BFFFh maps onto RAM at 10000h + (address - 8000h) when xramPresent is high, and is unmapped otherwise.
- R9: With bank bit 6 = 0, C000h-E7FFh maps onto RAM at the same address. With bit 6 = 1, C000h-DFFFh selects video RAM at address - C000h, and E000h-E7FFh is unmapped.
- R10: E800h-FFFFh maps onto RAM at the same address for every register value.
- R11: At most one chip select is asserted. A read that hits a device returns that device's data. A read that hits nothing, or a cycle with no read, returns FFh. A select asserts only during a read, or during a write to RAM or video RAM. physAddr is meaningful only while a select is asserted.
- R12: A register write with bits 3:2 = 3 or with bit 7 set raises errFlag, which then stays high until errClr is pulsed. A bad write in the same cycle as errClr leaves the flag high. Bit 7 has no effect on any decode.
- R13: A register write on regWrEn takes effect in the cycle after the clock edge that captures it. All decode is combinational from the address and the held register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | I/O strobe that loads the bank register |
| regWrData | input | 8 | Value for the bank register |
| errClr | input | 1 | Clears the sticky error flag |
| cpuAddr | input | 16 | CPU address |
| cpuRd | input | 1 | CPU memory read |
| cpuWr | input | 1 | CPU memory write |
| cartPresent | input | 1 | ROM cartridge fitted |
| xramPresent | input | 1 | More than 64 KB of RAM fitted |
| romRdData | input | 8 | Internal ROM read data |
| cartRdData | input | 8 | Cartridge ROM read data |
| ramRdData | input | 8 | RAM read data |
| vramRdData | input | 8 | Video RAM read data |
| romCs | output | 1 | Internal ROM select |
| cartCs | output | 1 | Cartridge ROM select |
| ramCs | output | 1 | RAM select (main and expansion) |
| vramCs | output | 1 | Video RAM select |
| physAddr | output | 17 | Translated physical address |
| memWe | output | 1 | Write enable to the selected RAM |
| cpuRdData | output | 8 | Read data returned to the CPU |
| bankReg | output | 8 | Current bank register value |
| errFlag | output | 1 | Sticky invalid-setting flag |

## Verification
The register is the block's only stored state, and the decode reads it without any delay. A wrong bit in it therefore appears in the same cycle as a wrong select, a shifted physical address, or FFh where data was expected. The sweep visits all 256 register values and both edges of every 1 KB block under each presence combination, so any corruption of a field shows up at once in the window that field controls. A wrongly held or wrongly cleared error flag shows directly on errFlag after the write that should have set it.

// File: rtl/bank_mapper_pkg.sv
package bank_mapper_pkg;
  localparam int CPU_AW     = 16;
  localparam int DATA_W     = 8;
  localparam int LOW_OFF_W  = 15;
  localparam int MID_OFF_W  = 14;
  localparam int VRAM_AW    = 13;
  localparam int ROM_PAGES  = 3;
  localparam int ROM_SEL_W  = 2;
  localparam int MID_SEL_W  = 2;
  localparam int PHYS_AW    = 17;

  // bank register field positions (software-visible encoding)
  localparam int ROM_LSB    = 0;
  localparam int LOW_LSB    = 2;
  localparam int MID_LSB    = 4;
  localparam int VRAM_BIT   = 6;
  localparam int SPARE_BIT  = 7;

  localparam logic [CPU_AW-1:0] MID_BASE   = 16'h8000;
  localparam logic [CPU_AW-1:0] SPLIT_BASE = 16'hC000;
  localparam logic [CPU_AW-1:0] HOLE_BASE  = 16'hE000;
  localparam logic [CPU_AW-1:0] FIXED_BASE = 16'hE800;

  localparam int NUM_DEV = 5;

  typedef enum logic [2:0] {
    DEV_NONE = 3'd0,
    DEV_ROM  = 3'd1,
    DEV_CART = 3'd2,
    DEV_RAM  = 3'd3,
    DEV_VRAM = 3'd4
  } devSel_t;

  typedef struct packed {
    logic                 lowRom;
    logic                 lowRamLo;
    logic                 lowRamHi;
    logic                 romCart;
    logic [ROM_SEL_W-1:0] romPage;
    logic                 midCart;
    logic [MID_SEL_W-1:0] midPage;
    logic                 vramOn;
  } bankStrobes_t;
endpackage

// File: rtl/bank_mapper_ctrl.sv
module bank_mapper_ctrl
  import bank_mapper_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [DATA_W-1:0] regWrData,
  input  logic              errClr,
  output logic [DATA_W-1:0] bankReg,
  output logic              errFlag,
  output bankStrobes_t      strobes
);
  logic badWrite;
  logic [1:0] lowSel;

  assign badWrite = regWrEn &&
                    ((regWrData[LOW_LSB+1:LOW_LSB] == 2'b11) || regWrData[SPARE_BIT]);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bankReg <= '0;
    end else if (regWrEn) begin
      bankReg <= regWrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      errFlag <= 1'b0;
    end else if (badWrite) begin
      errFlag <= 1'b1;
    end else if (errClr) begin
      errFlag <= 1'b0;
    end
  end

  assign lowSel = bankReg[LOW_LSB+1:LOW_LSB];

  always_comb begin
    strobes          = '0;
    strobes.lowRom   = (lowSel == 2'd0);
    strobes.lowRamLo = (lowSel == 2'd1);
    strobes.lowRamHi = (lowSel == 2'd2);
    strobes.romPage  = bankReg[ROM_LSB+ROM_SEL_W-1:ROM_LSB];
    strobes.romCart  = (int'(strobes.romPage) >= ROM_PAGES);
    strobes.midPage  = bankReg[MID_LSB+MID_SEL_W-1:MID_LSB];
    strobes.midCart  = (strobes.midPage == 2'b11);
    strobes.vramOn   = bankReg[VRAM_BIT];
  end
endmodule

// File: rtl/bank_mapper_dp.sv
module bank_mapper_dp
  import bank_mapper_pkg::*;
#(
  parameter logic [DATA_W-1:0] IDLE_VALUE = 8'hFF
) (
  input  logic [CPU_AW-1:0]  cpuAddr,
  input  logic               cpuRd,
  input  logic               cpuWr,
  input  logic               cartPresent,
  input  logic               xramPresent,
  input  bankStrobes_t       strobes,
  input  logic [DATA_W-1:0]  romRdData,
  input  logic [DATA_W-1:0]  cartRdData,
  input  logic [DATA_W-1:0]  ramRdData,
  input  logic [DATA_W-1:0]  vramRdData,
  output logic               romCs,
  output logic               cartCs,
  output logic               ramCs,
  output logic               vramCs,
  output logic [PHYS_AW-1:0] physAddr,
  output logic               memWe,
  output logic [DATA_W-1:0]  cpuRdData
);
  devSel_t            dev;
  logic [PHYS_AW-1:0] xlat;
  logic               writable;
  logic               access;
  logic [NUM_DEV-1:0] csVec;

  // window decode and address translation
  always_comb begin
    dev  = DEV_NONE;
    xlat = '0;
    if (cpuAddr < MID_BASE) begin
      if (strobes.lowRom) begin
        if (!strobes.romCart) begin
          dev  = DEV_ROM;
          xlat = PHYS_AW'({strobes.romPage, cpuAddr[LOW_OFF_W-1:0]});
        end else if (cartPresent) begin
          dev  = DEV_CART;
          xlat = PHYS_AW'(cpuAddr[LOW_OFF_W-1:0]);
        end
      end else if (strobes.lowRamLo) begin
        dev  = DEV_RAM;
        xlat = PHYS_AW'({1'b0, cpuAddr[LOW_OFF_W-1:0]});
      end else if (strobes.lowRamHi) begin
        dev  = DEV_RAM;
        xlat = PHYS_AW'({1'b1, cpuAddr[LOW_OFF_W-1:0]});
      end
    end else if (cpuAddr < SPLIT_BASE) begin
      if (!strobes.midCart) begin
        dev  = DEV_RAM;
        xlat = PHYS_AW'({strobes.midPage, cpuAddr[MID_OFF_W-1:0]});
      end else if (xramPresent) begin
        dev  = DEV_RAM;
        xlat = PHYS_AW'({1'b1, 2'b00, cpuAddr[MID_OFF_W-1:0]});
      end
    end else if (cpuAddr < FIXED_BASE) begin
      if (!strobes.vramOn) begin
        dev  = DEV_RAM;
        xlat = PHYS_AW'(cpuAddr);
      end else if (cpuAddr < HOLE_BASE) begin
        dev  = DEV_VRAM;
        xlat = PHYS_AW'(cpuAddr[VRAM_AW-1:0]);
      end
    end else begin
      dev  = DEV_RAM;
      xlat = PHYS_AW'(cpuAddr);
    end
  end

  assign writable = (dev == DEV_RAM) || (dev == DEV_VRAM);
  assign access   = cpuRd || (cpuWr && writable);

  for (genvar d = 0; d < NUM_DEV; d++) begin : g_cs
    if (d == 0) begin : g_none
      assign csVec[d] = 1'b0;
    end else begin : g_dev
      assign csVec[d] = access && (int'(dev) == d);
    end
  end

  assign romCs    = csVec[DEV_ROM];
  assign cartCs   = csVec[DEV_CART];
  assign ramCs    = csVec[DEV_RAM];
  assign vramCs   = csVec[DEV_VRAM];
  assign physAddr = (dev != DEV_NONE) ? xlat : '0;
  assign memWe    = cpuWr && writable;

  always_comb begin
    cpuRdData = IDLE_VALUE;
    if (cpuRd) begin
      case (dev)
        DEV_ROM:  cpuRdData = romRdData;
        DEV_CART: cpuRdData = cartRdData;
        DEV_RAM:  cpuRdData = ramRdData;
        DEV_VRAM: cpuRdData = vramRdData;
        default:  cpuRdData = IDLE_VALUE;
      endcase
    end
  end
endmodule

// File: rtl/bank_mapper.sv
module bank_mapper
  import bank_mapper_pkg::*;
#(
  parameter logic [7:0] IDLE_VALUE = 8'hFF
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic [7:0]  regWrData,
  input  logic        errClr,
  input  logic [15:0] cpuAddr,
  input  logic        cpuRd,
  input  logic        cpuWr,
  input  logic        cartPresent,
  input  logic        xramPresent,
  input  logic [7:0]  romRdData,
  input  logic [7:0]  cartRdData,
  input  logic [7:0]  ramRdData,
  input  logic [7:0]  vramRdData,
  output logic        romCs,
  output logic        cartCs,
  output logic        ramCs,
  output logic        vramCs,
  output logic [16:0] physAddr,
  output logic        memWe,
  output logic [7:0]  cpuRdData,
  output logic [7:0]  bankReg,
  output logic        errFlag
);
  bankStrobes_t strobes;

  bank_mapper_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .regWrEn   (regWrEn),
    .regWrData (regWrData),
    .errClr    (errClr),
    .bankReg   (bankReg),
    .errFlag   (errFlag),
    .strobes   (strobes)
  );

  bank_mapper_dp #(.IDLE_VALUE(IDLE_VALUE)) u_dp (
    .cpuAddr     (cpuAddr),
    .cpuRd       (cpuRd),
    .cpuWr       (cpuWr),
    .cartPresent (cartPresent),
    .xramPresent (xramPresent),
    .strobes     (strobes),
    .romRdData   (romRdData),
    .cartRdData  (cartRdData),
    .ramRdData   (ramRdData),
    .vramRdData  (vramRdData),
    .romCs       (romCs),
    .cartCs      (cartCs),
    .ramCs       (ramCs),
    .vramCs      (vramCs),
    .physAddr    (physAddr),
    .memWe       (memWe),
    .cpuRdData   (cpuRdData)
  );
endmodule

// File: rtl/bank_mapper_checker.sv
module bank_mapper_checker (
  input logic        clk,
  input logic        rstN,
  input logic        regWrEn,
  input logic [7:0]  regWrData,
  input logic        errClr,
  input logic [15:0] cpuAddr,
  input logic        cpuRd,
  input logic        cpuWr,
  input logic        cartPresent,
  input logic        romCs,
  input logic        cartCs,
  input logic        ramCs,
  input logic        vramCs,
  input logic [16:0] physAddr,
  input logic        memWe,
  input logic [7:0]  cpuRdData,
  input logic [7:0]  bankReg,
  input logic        errFlag
);
  assert_single_select_R11: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({romCs, cartCs, ramCs, vramCs}));

  assert_idle_read_R11: assert property (@(posedge clk) disable iff (!rstN)
    (cpuRd && !romCs && !cartCs && !ramCs && !vramCs) |-> (cpuRdData == 8'hFF));

  assert_absent_cart_R3: assert property (@(posedge clk) disable iff (!rstN)
    !cartPresent |-> !cartCs);

  assert_rom_write_ignored_R4: assert property (@(posedge clk) disable iff (!rstN)
    (cpuWr && !cpuRd && cpuAddr < 16'h8000 && bankReg[3:2] == 2'b00)
      |-> (!memWe && !romCs && !cartCs));

  assert_fixed_window_R10: assert property (@(posedge clk) disable iff (!rstN)
    ((cpuRd || cpuWr) && cpuAddr >= 16'hE800) |-> (ramCs && physAddr == {1'b0, cpuAddr}));

  assert_flag_sticky_R12: assert property (@(posedge clk) disable iff (!rstN)
    (errFlag && !errClr) |=> errFlag);

  assert_reg_load_R13: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |=> (bankReg == $past(regWrData)));
endmodule

bind bank_mapper bank_mapper_checker u_checker (
  .clk         (clk),
  .rstN        (rstN),
  .regWrEn     (regWrEn),
  .regWrData   (regWrData),
  .errClr      (errClr),
  .cpuAddr     (cpuAddr),
  .cpuRd       (cpuRd),
  .cpuWr       (cpuWr),
  .cartPresent (cartPresent),
  .romCs       (romCs),
  .cartCs      (cartCs),
  .ramCs       (ramCs),
  .vramCs      (vramCs),
  .physAddr    (physAddr),
  .memWe       (memWe),
  .cpuRdData   (cpuRdData),
  .bankReg     (bankReg),
  .errFlag     (errFlag)
);

// File: tb/bank_mapper_bench.sv
`timescale 1ns/1ps
module bank_mapper_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [7:0]  regWrData = '0;
  logic        errClr = 1'b0;
  logic [15:0] cpuAddr = '0;
  logic        cpuRd = 1'b0;
  logic        cpuWr = 1'b0;
  logic        cartPresent = 1'b0;
  logic        xramPresent = 1'b0;
  logic [7:0]  romRdData  = 8'h5A;
  logic [7:0]  cartRdData = 8'hC3;
  logic [7:0]  ramRdData  = 8'h69;
  logic [7:0]  vramRdData = 8'h96;
  logic        romCs, cartCs, ramCs, vramCs, memWe, errFlag;
  logic [16:0] physAddr;
  logic [7:0]  cpuRdData, bankReg;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  bank_mapper u_bank_mapper (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrData(regWrData), .errClr(errClr),
    .cpuAddr(cpuAddr), .cpuRd(cpuRd), .cpuWr(cpuWr),
    .cartPresent(cartPresent), .xramPresent(xramPresent),
    .romRdData(romRdData), .cartRdData(cartRdData), .ramRdData(ramRdData), .vramRdData(vramRdData),
    .romCs(romCs), .cartCs(cartCs), .ramCs(ramCs), .vramCs(vramCs),
    .physAddr(physAddr), .memWe(memWe), .cpuRdData(cpuRdData),
    .bankReg(bankReg), .errFlag(errFlag)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h (reg %h addr %h rd %b wr %b)",
               tag, act, exp, bankReg, cpuAddr, cpuRd, cpuWr);
    end
  endtask

  // packed port view: {cs[3:0] rom,cart,ram,vram ; we ; rdData ; physAddr if selected}
  function automatic logic [31:0] portView();
    logic [3:0] cs;
    cs = {romCs, cartCs, ramCs, vramCs};
    return {2'b00, cs, memWe, cpuRdData, (|cs) ? physAddr : 17'h0};
  endfunction

  // mode: 0 read, 1 write, 2 no access
  function automatic logic [31:0] model(input logic [7:0] r, input int a, input int mode,
                                        input logic cp, input logic xp);
    int dev, pa;
    logic rd, wr, wrt, on;
    logic [3:0] cs;
    logic [7:0] d;
    dev = 0; pa = 0;
    rd = (mode == 0); wr = (mode == 1);
    if (a < 32768) begin
      case (int'(r[3:2]))
        0: if (r[1:0] != 2'd3) begin dev = 1; pa = int'(r[1:0]) * 32768 + a; end
           else if (cp) begin dev = 2; pa = a; end
        1: begin dev = 3; pa = a; end
        2: begin dev = 3; pa = a + 32768; end
        default: dev = 0;
      endcase
    end else if (a < 49152) begin
      if (r[5:4] != 2'd3) begin dev = 3; pa = int'(r[5:4]) * 16384 + (a - 32768); end
      else if (xp) begin dev = 3; pa = 65536 + (a - 32768); end
    end else if (a < 59392) begin
      if (!r[6]) begin dev = 3; pa = a; end
      else if (a < 57344) begin dev = 4; pa = a - 49152; end
    end else begin
      dev = 3; pa = a;
    end
    wrt = (dev >= 3);
    on = (dev != 0) && (rd || (wr && wrt));
    cs = on ? (4'b1000 >> (dev - 1)) : 4'b0000;
    d = 8'hFF;
    if (rd) begin
      case (dev)
        1: d = 8'h5A;
        2: d = 8'hC3;
        3: d = 8'h69;
        4: d = 8'h96;
        default: d = 8'hFF;
      endcase
    end
    return {2'b00, cs, wr && wrt, d, on ? pa[16:0] : 17'h0};
  endfunction

  function automatic string tagOf(input logic [7:0] r, input int a, input int mode);
    if (mode == 2) return "R11";
    if (a < 32768) begin
      if (r[3:2] == 2'd0) return (mode == 1) ? "R4" : ((r[1:0] == 2'd3) ? "R3" : "R2");
      if (r[3:2] == 2'd3) return "R6";
      return "R5";
    end
    if (a < 49152) return (r[5:4] == 2'd3) ? "R8" : "R7";
    if (a < 59392) return "R9";
    return "R10";
  endfunction

  task automatic writeReg(input logic [7:0] v, input logic clr);
    @(negedge clk);
    regWrEn = 1'b1; regWrData = v; errClr = clr;
    @(negedge clk);
    regWrEn = 1'b0; errClr = 1'b0;
  endtask

  task automatic pulseClr();
    @(negedge clk);
    errClr = 1'b1;
    @(negedge clk);
    errClr = 1'b0;
  endtask

  task automatic access(input int a, input int mode);
    cpuAddr = a[15:0];
    cpuRd = (mode == 0);
    cpuWr = (mode == 1);
    #1;
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic flagModel;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 reg", {24'h0, bankReg}, 32'h0);
    check("R1 flag", {31'h0, errFlag}, 32'h0);
    access(16'h1234, 0);
    check("R1 decode", portView(), model(8'h00, 16'h1234, 0, 1'b0, 1'b0));

    // R13: change applies only after the capturing edge
    @(negedge clk);
    cpuAddr = 16'h0010; cpuRd = 1'b1;
    regWrEn = 1'b1; regWrData = 8'h04;
    #1;
    check("R13 before edge", portView(), model(8'h00, 16'h0010, 0, 1'b0, 1'b0));
    @(posedge clk); #1;
    regWrEn = 1'b0;
    #0.5;
    check("R13 after edge", portView(), model(8'h04, 16'h0010, 0, 1'b0, 1'b0));

    // R12 sticky flag
    writeReg(8'h0C, 1'b0);
    check("R12 set by bits 3:2", {31'h0, errFlag}, 32'h1);
    access(16'h4000, 0);
    check("R6 unmapped read", portView(), model(8'h0C, 16'h4000, 0, 1'b1, 1'b1));
    writeReg(8'h00, 1'b0);
    check("R12 stays set", {31'h0, errFlag}, 32'h1);
    pulseClr();
    check("R12 cleared", {31'h0, errFlag}, 32'h0);
    writeReg(8'h80, 1'b0);
    check("R12 set by bit 7", {31'h0, errFlag}, 32'h1);
    access(16'h0100, 0);
    check("R12 bit 7 no decode effect", portView(), model(8'h00, 16'h0100, 0, 1'b0, 1'b0));
    pulseClr();
    writeReg(8'h0C, 1'b1);
    check("R12 set beats clear", {31'h0, errFlag}, 32'h1);
    pulseClr();
    check("R12 cleared again", {31'h0, errFlag}, 32'h0);

    // exhaustive register sweep
    flagModel = 1'b0;
    for (int r = 0; r < 256; r++) begin
      writeReg(r[7:0], 1'b0);
      if (r[3:2] == 2'b11 || r[7]) flagModel = 1'b1;
      check("R13 reg load", {24'h0, bankReg}, {24'h0, r[7:0]});
      check("R12 flag track", {31'h0, errFlag}, {31'h0, flagModel});
      for (int pres = 0; pres < 4; pres++) begin
        cartPresent = pres[0];
        xramPresent = pres[1];
        for (int blk = 0; blk < 64; blk++) begin
          for (int edge_ = 0; edge_ < 2; edge_++) begin
            for (int mode = 0; mode < 3; mode++) begin
              int a;
              a = blk * 1024 + edge_ * 1023;
              access(a, mode);
              check(tagOf(r[7:0], a, mode), portView(),
                    model(r[7:0], a, mode, pres[0], pres[1]));
            end
          end
        end
      end
    end
    cpuRd = 1'b0; cpuWr = 1'b0;

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule